// File: doc/BRIEF.md
# Three-Address Memory-Operand Processor

This block is a small single-issue processor with split program and data storage and no register file. Each instruction names two source locations and one destination location in data memory by absolute address. The core reads both operands, combines them, and either writes the result back to data memory or, for the equality branch, treats the destination field as a jump target. Every instruction runs to completion before the next fetch begins, so no hazard logic is needed.

The core attaches to a synchronous instruction memory (one read port) and a synchronous data memory with two read ports and one write port. Both memories return read data one clock after the address is presented. The processor stops at a halt instruction and signals this on a status output until the next reset.

Control is a five-state machine. FETCH presents the program counter and goes to DECODE. DECODE latches the returned word and goes to HALTED if the opcode is halt, otherwise to OPERAND. OPERAND presents both source addresses and goes to EXECUTE. EXECUTE computes, writes or branches, updates the program counter and returns to FETCH. HALTED has only a self-loop. Reset returns the machine to FETCH.

Top module: `mm3_core`

## Requirements
- R1: While reset is asserted, `halted` is 0, `dmem_we` is 0 and `imem_addr` is 0.
- R2: An instruction word is fetched from `imem_addr`, which equals the program counter. After any instruction other than a taken branch or halt, the next fetch address is the previous one plus one, modulo 2^10.
- R3: Word layout: opcode in bits [31:30] (0 add, 1 subtract, 2 branch-if-equal, 3 halt), first source in [29:20], second source in [19:10], destination in [9:0]. The operand reads are issued on `dmem_raddr_a`/`dmem_raddr_b` at the first and second source fields.
- R4: Add writes (a + b) mod 2^16 to data memory at the destination field.
- R5: Subtract writes (a − b) mod 2^16, where a comes from the first source field, to the destination field.
- R6: Branch-if-equal with equal operands performs no data write, and the next fetch address is the destination field.
- R7: Branch-if-equal with unequal operands performs no data write, and execution continues at the next sequential address.
- R8: Halt raises `halted`. From then until reset, `halted` stays 1, `imem_addr` holds the address of the halt instruction, and no data write occurs.
- R9: A non-halt instruction takes exactly four clocks. Halt reaches the halted state two clocks after its fetch begins. Each add or subtract asserts `dmem_we` for exactly one clock.
- R10: A value written by one instruction is the value read by any later instruction that names the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 10 | Instruction memory read address (program counter) |
| imem_rdata | input | 32 | Instruction word, valid one clock after address |
| dmem_raddr_a | output | 10 | Data read port A address (first source) |
| dmem_rdata_a | input | 16 | Data read port A value, one clock latency |
| dmem_raddr_b | output | 10 | Data read port B address (second source) |
| dmem_rdata_b | input | 16 | Data read port B value, one clock latency |
| dmem_we | output | 1 | Data write enable |
| dmem_waddr | output | 10 | Data write address |
| dmem_wdata | output | 16 | Data write value |
| halted | output | 1 | Core has executed halt |

## Verification
Nearly all internal state is visible at the ports within one instruction. A wrong program counter shows on `imem_addr` at the next fetch. A wrong latched field shows on the operand or write addresses within two clocks. A wrong ALU result is stored at the destination and appears in data memory when the instruction completes. A wrong branch decision changes the path through the program, and therefore the set of locations written, the clock count to halt and the address at which the core halts.

// File: rtl/mm3_pkg.sv
package mm3_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_BEQ  = 2'd2,
        OP_HALT = 2'd3
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND,
        ST_EXECUTE,
        ST_HALTED
    } core_state_e;

endpackage

// File: rtl/mm3_decode.sv
// Instruction register with field split. Bits above the four fields are padding.
module mm3_decode
    import mm3_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [INSTR_W-1:0] word,
    output logic               raw_is_halt,
    output opcode_e            op,
    output logic [ADDR_W-1:0]  src1,
    output logic [ADDR_W-1:0]  src2,
    output logic [ADDR_W-1:0]  dst
);
    localparam int OP_LSB   = INSTR_W - OP_W;
    localparam int SRC1_LSB = 2 * ADDR_W;
    localparam int SRC2_LSB = ADDR_W;
    localparam int DST_LSB  = 0;

    opcode_e raw_op;

    always_comb begin
        raw_op      = opcode_e'(word[OP_LSB +: OP_W]);
        raw_is_halt = (raw_op == OP_HALT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op   <= OP_ADD;
            src1 <= '0;
            src2 <= '0;
            dst  <= '0;
        end else if (load) begin
            op   <= raw_op;
            src1 <= word[SRC1_LSB +: ADDR_W];
            src2 <= word[SRC2_LSB +: ADDR_W];
            dst  <= word[DST_LSB  +: ADDR_W];
        end
    end

endmodule

// File: rtl/mm3_alu.sv
module mm3_alu
    import mm3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              equal,
    output logic              wr_req
);
    always_comb begin
        result = '0;
        wr_req = 1'b0;
        equal  = (a == b);
        unique case (op)
            OP_ADD: begin
                result = a + b;
                wr_req = 1'b1;
            end
            OP_SUB: begin
                result = a - b;
                wr_req = 1'b1;
            end
            OP_BEQ:  result = '0;
            OP_HALT: result = '0;
        endcase
    end

endmodule

// File: rtl/mm3_pc.sv
module mm3_pc #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              take,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] pc_next;

    always_comb begin
        pc_next = pc + 1'b1;
        if (take) begin
            pc_next = target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (advance) begin
            pc <= pc_next;
        end
    end

endmodule

// File: rtl/mm3_ctrl.sv
module mm3_ctrl
    import mm3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_is_halt,
    output logic ir_load,
    output logic exec,
    output logic halted
);
    core_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   state_nx = ST_DECODE;
            ST_DECODE:  state_nx = raw_is_halt ? ST_HALTED : ST_OPERAND;
            ST_OPERAND: state_nx = ST_EXECUTE;
            ST_EXECUTE: state_nx = ST_FETCH;
            ST_HALTED:  state_nx = ST_HALTED;
            default:    state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        ir_load = 1'b0;
        exec    = 1'b0;
        halted  = 1'b0;
        unique case (state)
            ST_FETCH:   ir_load = 1'b0;
            ST_DECODE:  ir_load = 1'b1;
            ST_OPERAND: ir_load = 1'b0;
            ST_EXECUTE: exec    = 1'b1;
            ST_HALTED:  halted  = 1'b1;
            default:    halted  = 1'b0;
        endcase
    end

endmodule

// File: rtl/mm3_core.sv
// Requires INSTR_W >= OP_W + 3*ADDR_W.
module mm3_core
    import mm3_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 10,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]  dmem_raddr_a,
    input  logic [DATA_W-1:0]  dmem_rdata_a,
    output logic [ADDR_W-1:0]  dmem_raddr_b,
    input  logic [DATA_W-1:0]  dmem_rdata_b,
    output logic               dmem_we,
    output logic [ADDR_W-1:0]  dmem_waddr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               halted
);
    logic              raw_is_halt, ir_load, exec, eq, wr_req;
    opcode_e           op;
    logic [ADDR_W-1:0] src1, src2, dst, pc;
    logic [DATA_W-1:0] alu_out;

    mm3_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_is_halt(raw_is_halt),
        .ir_load    (ir_load),
        .exec       (exec),
        .halted     (halted)
    );

    mm3_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ir_load),
        .word       (imem_rdata),
        .raw_is_halt(raw_is_halt),
        .op         (op),
        .src1       (src1),
        .src2       (src2),
        .dst        (dst)
    );

    mm3_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (op),
        .a     (dmem_rdata_a),
        .b     (dmem_rdata_b),
        .result(alu_out),
        .equal (eq),
        .wr_req(wr_req)
    );

    mm3_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(exec),
        .take   ((op == OP_BEQ) && eq),
        .target (dst),
        .pc     (pc)
    );

    always_comb begin
        imem_addr    = pc;
        dmem_raddr_a = src1;
        dmem_raddr_b = src2;
        dmem_waddr   = dst;
        dmem_wdata   = alu_out;
        dmem_we      = exec && wr_req;
    end

endmodule

// File: rtl/mm3_core_chk.sv
module mm3_core_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [ADDR_W-1:0] dmem_raddr_a,
    input logic [ADDR_W-1:0] dmem_raddr_b,
    input logic              dmem_we,
    input logic              halted
);
    AST_WRITE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we); // R9

    AST_PC_STEP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (imem_addr == $past(imem_addr) + 1'b1)); // R2

    AST_OPERAND_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> ($stable(dmem_raddr_a) && $stable(dmem_raddr_b))); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!dmem_we && $stable(imem_addr))); // R8

endmodule

bind mm3_core mm3_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .imem_addr   (imem_addr),
    .dmem_raddr_a(dmem_raddr_a),
    .dmem_raddr_b(dmem_raddr_b),
    .dmem_we     (dmem_we),
    .halted      (halted)
);

// File: tb/tb_mm3_core.sv
module tb_mm3_core;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 10;
    localparam int IW = 32;
    localparam int MEM_D = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] imem_addr, dmem_raddr_a, dmem_raddr_b, dmem_waddr;
    logic [IW-1:0] imem_rdata;
    logic [DW-1:0] dmem_rdata_a, dmem_rdata_b, dmem_wdata;
    logic          dmem_we, halted;

    logic [IW-1:0] imem [MEM_D];
    logic [DW-1:0] dmem [MEM_D];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    int n_checks = 0;
    int n_errors = 0;
    int run_cycles, run_writes;
    logic [AW-1:0] first_ra, first_rb, first_wa;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        imem_rdata   <= imem[imem_addr];
        dmem_rdata_a <= dmem[dmem_raddr_a];
        dmem_rdata_b <= dmem[dmem_raddr_b];
        if (ld_en) dmem[ld_addr] <= ld_data;
        else if (dmem_we) dmem[dmem_waddr] <= dmem_wdata;
    end

    mm3_core #(.DATA_W(DW), .ADDR_W(AW), .INSTR_W(IW)) dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_raddr_a(dmem_raddr_a), .dmem_rdata_a(dmem_rdata_a),
        .dmem_raddr_b(dmem_raddr_b), .dmem_rdata_b(dmem_rdata_b),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .halted(halted)
    );

    function automatic logic [IW-1:0] enc(input int op, input int s1, input int s2, input int d);
        return {op[1:0], s1[AW-1:0], s2[AW-1:0], d[AW-1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic dset(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a[AW-1:0]; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Hold reset, clear low memory, leave program loading to the caller.
    task automatic prep();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dset(i, '0);
        end
    endtask

    task automatic run_until_halt(input int limit);
        run_cycles = 0;
        run_writes = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!halted && run_cycles < limit) begin
            @(posedge clk);
            run_cycles++;
            @(negedge clk);
            if (dmem_we) begin
                run_writes++;
                if (run_writes == 1) begin
                    first_ra = dmem_raddr_a;
                    first_rb = dmem_raddr_b;
                    first_wa = dmem_waddr;
                end
            end
        end
        if (!halted) chk("R8 run did not halt", 32'(halted), 32'd1);
    endtask

    task automatic t_reset();
        prep();
        @(negedge clk);
        chk("R1 halted in reset", 32'(halted), 32'd0);
        chk("R1 dmem_we in reset", 32'(dmem_we), 32'd0);
        chk("R1 imem_addr in reset", 32'(imem_addr), 32'd0);
    endtask

    task automatic t_arith();
        prep();
        dset(1, 16'd100);
        dset(2, 16'd23);
        dset(3, 16'h7FFF);
        dset(4, 16'hFFFF);
        dset(5, 16'h0002);
        imem[0] = enc(0, 1, 2, 10);
        imem[1] = enc(1, 1, 2, 11);
        imem[2] = enc(1, 2, 1, 12);
        imem[3] = enc(0, 3, 3, 13);
        imem[4] = enc(0, 4, 5, 14);
        imem[5] = enc(3, 0, 0, 0);
        run_until_halt(500);
        chk("R4 add 100+23", 32'(dmem[10]), 32'd123);
        chk("R5 sub 100-23", 32'(dmem[11]), 32'd77);
        chk("R5 sub 23-100 wraps", 32'(dmem[12]), 32'h0000FFB3);
        chk("R4 add 7FFF+7FFF wraps", 32'(dmem[13]), 32'h0000FFFE);
        chk("R4 add FFFF+2 wraps", 32'(dmem[14]), 32'd1);
        chk("R3 first read port A addr", 32'(first_ra), 32'd1);
        chk("R3 first read port B addr", 32'(first_rb), 32'd2);
        chk("R3 first write addr", 32'(first_wa), 32'd10);
        chk("R9 clocks to halt", 32'(run_cycles), 32'd22);
        chk("R9 write pulses", 32'(run_writes), 32'd5);
        chk("R2 halt address", 32'(imem_addr), 32'd5);
    endtask

    task automatic t_branch();
        prep();
        dset(1, 16'd7);
        dset(2, 16'd7);
        dset(3, 16'd8);
        imem[0] = enc(2, 1, 3, 9);
        imem[1] = enc(2, 1, 2, 5);
        imem[2] = enc(0, 1, 1, 20);
        imem[3] = enc(0, 1, 1, 20);
        imem[4] = enc(0, 1, 1, 20);
        imem[5] = enc(0, 1, 2, 21);
        imem[6] = enc(3, 0, 0, 0);
        imem[9] = enc(3, 0, 0, 0);
        run_until_halt(500);
        chk("R7 unequal falls through, halt address", 32'(imem_addr), 32'd6);
        chk("R6 skipped code left untouched", 32'(dmem[20]), 32'd0);
        chk("R6 branch target executed", 32'(dmem[21]), 32'd14);
        chk("R6 R7 branches make no write", 32'(run_writes), 32'd1);
        chk("R9 clocks to halt on branch path", 32'(run_cycles), 32'd14);
    endtask

    task automatic t_chain_and_hold();
        int bad;
        prep();
        dset(1, 16'd5);
        imem[0] = enc(0, 1, 1, 2);
        imem[1] = enc(0, 2, 2, 3);
        imem[2] = enc(1, 3, 1, 4);
        imem[3] = enc(3, 0, 0, 0);
        run_until_halt(500);
        chk("R10 chained result", 32'(dmem[4]), 32'd15);
        chk("R10 intermediate result", 32'(dmem[3]), 32'd20);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!halted || dmem_we || imem_addr != 10'd3) bad++;
        end
        chk("R8 halted state holds", 32'(bad), 32'd0);
        chk("R8 memory unchanged after halt", 32'(dmem[4]), 32'd15);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_D; i++) begin
            imem[i] = '0;
        end
        t_reset();
        t_arith();
        t_branch();
        t_chain_and_hold();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule